// File: doc/BRIEF.md
# Typematic Key Repeat Controller

This block sits between a key source and a consumer of keystrokes. The key source polls a key matrix at its own pace and offers one keycode per poll strobe. The block decides whether that poll becomes a keystroke for the consumer. A key that differs from the one last accepted is forwarded straight away. A key that stays held is forwarded again only after a long first pause, and after that at a quicker steady rhythm. Both pauses are counted in polls, not in clock cycles, so the poll rate of the key source sets the real-time rhythm.

A keycode of zero means that no key is down. It clears the remembered key, so that pressing the same key again counts as a fresh keystroke. A test-mode input selects what a zero poll produces. In test mode it produces an explicit "no key" result with keycode 0. In normal mode it is absorbed and produces no result, so that a consumer waiting for a real key sees nothing.

Top module: `typematic_repeat`

## Requirements
- R1: After reset, `out_valid_o` is low and `key_o` is 0. The remembered key is 0, so the first nonzero poll after reset is forwarded at once, even when it carries the key that was held before the reset.
- R2: `out_valid_o` rises only in the clock cycle right after a cycle with `poll_i` high, and stays high for exactly one cycle. A cycle without a poll never produces a result.
- R3: A poll carrying a nonzero key that differs from the remembered key is forwarded on `key_o` one cycle later, and that key becomes the remembered key.
- R4: After a new key is forwarded, the next INIT_DELAY polls (default 20) that repeat the same key produce no result. The poll after those is forwarded.
- R5: After a repeat is forwarded, the next REPEAT_RATE polls (default 4) that repeat the same key produce no result. The poll after those is forwarded. This rhythm continues for as long as the key is held.
- R6: A poll with keycode 0 clears the remembered key, so that a following poll of the previously held key is forwarded at once.
- R7: With `test_mode_i` high, a poll with keycode 0 produces a result one cycle later with `out_valid_o` high and `key_o` equal to 0.
- R8: With `test_mode_i` low, a poll with keycode 0 produces no result.
- R9: A different nonzero key that arrives while another key is held is forwarded at once, and the full INIT_DELAY pause then starts again for that new key.
- R10: Idle cycles between polls neither advance nor reset the repeat pauses. Only polls are counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| poll_i | input | 1 | Strobe: `key_i` holds one polled keycode this cycle |
| key_i | input | KEY_W | Polled keycode; 0 means no key down |
| test_mode_i | input | 1 | High: a zero poll yields a "no key" result of 0 |
| out_valid_o | output | 1 | One-cycle strobe: `key_o` carries a result |
| key_o | output | KEY_W | Forwarded keycode, or 0 for a "no key" result |

## Verification
Every result appears exactly one clock after the poll that caused it, because only one register stage lies between the poll and the output. The bench therefore drives each poll at a falling edge and reads the outputs at the next falling edge, before it drives the next input. In this way every poll is paired with the one cycle in which its result is due. Cycles without a poll are checked in the same way to confirm that the output stays silent. The held-key sequences count polls exactly across the 20-poll and 4-poll boundaries, with and without idle gaps between polls.

// File: rtl/typrep_pkg.sv
package typrep_pkg;

    // What a single clock cycle does to the repeat state
    typedef enum logic [2:0] {
        TR_IDLE    = 3'd0,  // no poll this cycle
        TR_FRESH   = 3'd1,  // new key: forward, remember, start long pause
        TR_AGAIN   = 3'd2,  // held key, pause over: forward, start short pause
        TR_HOLD    = 3'd3,  // held key, pause running: count down, silent
        TR_RELEASE = 3'd4   // zero key: forget key, maybe report "no key"
    } tr_act_e;

    function automatic int tr_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic tr_act_e tr_pick(
        input logic poll,
        input logic key_zero,
        input logic same_key,
        input logic expired
    );
        if (!poll)          return TR_IDLE;
        else if (key_zero)  return TR_RELEASE;
        else if (!same_key) return TR_FRESH;
        else if (expired)   return TR_AGAIN;
        else                return TR_HOLD;
    endfunction

    // Does this action put a result on the output?
    function automatic logic tr_emits(input tr_act_e act, input logic test_mode);
        return (act == TR_FRESH) || (act == TR_AGAIN) ||
               ((act == TR_RELEASE) && test_mode);
    endfunction

endpackage

// File: rtl/typrep_key_store.sv
module typrep_key_store
    import typrep_pkg::*;
#(
    parameter int KEY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  tr_act_e          act,
    input  logic [KEY_W-1:0] key_in,
    output logic             same_key,
    output logic             key_zero
);
    logic [KEY_W-1:0] held_q;

    // R1 R3 R6: remembered key
    always_ff @(posedge clk) begin
        if (rst)
            held_q <= '0;
        else if (act == TR_FRESH)
            held_q <= key_in;
        else if (act == TR_RELEASE)
            held_q <= '0;
    end

    assign same_key = (key_in == held_q);
    assign key_zero = (key_in == '0);
endmodule

// File: rtl/typrep_timer.sv
module typrep_timer
    import typrep_pkg::*;
#(
    parameter int INIT_DELAY  = 20,
    parameter int REPEAT_RATE = 4,
    parameter int CNT_W       = 5
) (
    input  logic    clk,
    input  logic    rst,
    input  tr_act_e act,
    output logic    expired
);
    localparam logic [CNT_W-1:0] LOAD_LONG  = CNT_W'(INIT_DELAY);
    localparam logic [CNT_W-1:0] LOAD_SHORT = CNT_W'(REPEAT_RATE);

    logic [CNT_W-1:0] left_q;

    // R4 R5 R9 R10: the count moves only on polls
    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= LOAD_LONG;
        end else begin
            unique case (act)
                TR_FRESH, TR_RELEASE: left_q <= LOAD_LONG;
                TR_AGAIN:             left_q <= LOAD_SHORT;
                TR_HOLD:              left_q <= left_q - 1'b1;
                default:              left_q <= left_q;
            endcase
        end
    end

    assign expired = (left_q == '0);
endmodule

// File: rtl/typrep_emit.sv
module typrep_emit
    import typrep_pkg::*;
#(
    parameter int KEY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  tr_act_e          act,
    input  logic             test_mode,
    input  logic [KEY_W-1:0] key_in,
    output logic             valid_o,
    output logic [KEY_W-1:0] key_o
);
    logic fire;
    assign fire = tr_emits(act, test_mode);

    // R2 R7: one-cycle result strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            key_o   <= '0;
        end else begin
            valid_o <= fire;
            if (fire)
                key_o <= (act == TR_RELEASE) ? '0 : key_in;
        end
    end
endmodule

// File: rtl/typematic_repeat.sv
module typematic_repeat
    import typrep_pkg::*;
#(
    parameter int KEY_W       = 8,
    parameter int INIT_DELAY  = 20,
    parameter int REPEAT_RATE = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             poll_i,
    input  logic [KEY_W-1:0] key_i,
    input  logic             test_mode_i,
    output logic             out_valid_o,
    output logic [KEY_W-1:0] key_o
);
    localparam int MAX_LOAD = tr_max(INIT_DELAY, REPEAT_RATE);
    localparam int CNT_W    = (MAX_LOAD < 1) ? 1 : $clog2(MAX_LOAD + 1);

    logic    same_key;
    logic    key_zero;
    logic    expired;
    tr_act_e act;

    assign act = tr_pick(poll_i, key_zero, same_key, expired);

    typrep_key_store #(.KEY_W(KEY_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .act      (act),
        .key_in   (key_i),
        .same_key (same_key),
        .key_zero (key_zero)
    );

    typrep_timer #(
        .INIT_DELAY  (INIT_DELAY),
        .REPEAT_RATE (REPEAT_RATE),
        .CNT_W       (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .act     (act),
        .expired (expired)
    );

    typrep_emit #(.KEY_W(KEY_W)) u_emit (
        .clk       (clk),
        .rst       (rst),
        .act       (act),
        .test_mode (test_mode_i),
        .key_in    (key_i),
        .valid_o   (out_valid_o),
        .key_o     (key_o)
    );
endmodule

// File: rtl/typrep_chk.sv
module typrep_chk #(
    parameter int KEY_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             poll_i,
    input logic [KEY_W-1:0] key_i,
    input logic             test_mode_i,
    input logic             out_valid_o,
    input logic [KEY_W-1:0] key_o
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!out_valid_o && key_o == '0));

    // R2
    no_poll_silent_chk: assert property (@(posedge clk) disable iff (rst)
        !poll_i |=> !out_valid_o);

    // R3
    echo_key_chk: assert property (@(posedge clk) disable iff (rst)
        (poll_i && key_i != '0) |=> (!out_valid_o || key_o == $past(key_i)));

    // R4 R5
    no_back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && key_o != '0 && poll_i && key_i == key_o) |=> !out_valid_o);

    // R7
    test_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (poll_i && key_i == '0 && test_mode_i) |=> (out_valid_o && key_o == '0));

    // R8
    normal_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (poll_i && key_i == '0 && !test_mode_i) |=> !out_valid_o);
endmodule

bind typematic_repeat typrep_chk #(.KEY_W(KEY_W)) u_typrep_chk (
    .clk         (clk),
    .rst         (rst),
    .poll_i      (poll_i),
    .key_i       (key_i),
    .test_mode_i (test_mode_i),
    .out_valid_o (out_valid_o),
    .key_o       (key_o)
);

// File: tb/typematic_repeat_test.sv
module typematic_repeat_test;
    localparam int KW = 8;
    localparam int NV = 18;

    typedef struct packed {
        logic [3:0]    req;
        logic          test;
        logic [KW-1:0] key;
        logic [5:0]    reps;
        logic          ev;
        logic [KW-1:0] ek;
    } vec_t;

    // Each row: apply `reps` consecutive polls of `key`, expecting ev/ek after each
    localparam vec_t VECS [NV] = '{
        '{4'd3,  1'b0, 8'h41, 6'd1,  1'b1, 8'h41},  // R3 new key
        '{4'd4,  1'b0, 8'h41, 6'd20, 1'b0, 8'h00},  // R4 long pause
        '{4'd4,  1'b0, 8'h41, 6'd1,  1'b1, 8'h41},  // R4 first repeat
        '{4'd5,  1'b0, 8'h41, 6'd4,  1'b0, 8'h00},  // R5 short pause
        '{4'd5,  1'b0, 8'h41, 6'd1,  1'b1, 8'h41},  // R5
        '{4'd5,  1'b0, 8'h41, 6'd4,  1'b0, 8'h00},  // R5
        '{4'd5,  1'b0, 8'h41, 6'd1,  1'b1, 8'h41},  // R5
        '{4'd9,  1'b0, 8'h42, 6'd1,  1'b1, 8'h42},  // R9 other key
        '{4'd9,  1'b0, 8'h42, 6'd20, 1'b0, 8'h00},  // R9 full pause again
        '{4'd9,  1'b0, 8'h42, 6'd1,  1'b1, 8'h42},  // R9
        '{4'd8,  1'b0, 8'h00, 6'd1,  1'b0, 8'h00},  // R8 silent zero
        '{4'd6,  1'b0, 8'h42, 6'd1,  1'b1, 8'h42},  // R6 same key again
        '{4'd6,  1'b0, 8'h42, 6'd3,  1'b0, 8'h00},  // R6
        '{4'd7,  1'b1, 8'h00, 6'd3,  1'b1, 8'h00},  // R7 no-key reports
        '{4'd6,  1'b1, 8'h42, 6'd1,  1'b1, 8'h42},  // R6 after test zero
        '{4'd4,  1'b1, 8'h42, 6'd19, 1'b0, 8'h00},  // R4 test mode keeps pause
        '{4'd4,  1'b1, 8'h42, 6'd1,  1'b0, 8'h00},  // R4 20th silent poll
        '{4'd4,  1'b1, 8'h42, 6'd1,  1'b1, 8'h42}   // R4 boundary
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          poll_i;
    logic [KW-1:0] key_i;
    logic          test_mode_i;
    logic          out_valid_o;
    logic [KW-1:0] key_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    typematic_repeat uut (
        .clk         (clk),
        .rst         (rst),
        .poll_i      (poll_i),
        .key_i       (key_i),
        .test_mode_i (test_mode_i),
        .out_valid_o (out_valid_o),
        .key_o       (key_o)
    );

    task automatic expect_out(input string tag, input logic ev, input logic [KW-1:0] ek);
        n_checks++;
        if (out_valid_o !== ev || (ev && key_o !== ek)) begin
            n_fails++;
            $display("FAIL %s: valid=%0b key=%02h, expected valid=%0b key=%02h",
                     tag, out_valid_o, key_o, ev, ek);
        end
    endtask

    // Poll once (driven at a falling edge), then check the result one clock later
    task automatic poll_once(input string tag, input logic [KW-1:0] k, input logic tm,
                             input logic ev, input logic [KW-1:0] ek);
        poll_i      = 1'b1;
        key_i       = k;
        test_mode_i = tm;
        @(negedge clk);
        poll_i = 1'b0;
        expect_out(tag, ev, ek);
    endtask

    task automatic idle(input string tag, input int n);
        poll_i = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            expect_out(tag, 1'b0, 8'h00);
        end
    endtask

    task automatic do_reset();
        rst    = 1'b1;
        poll_i = 1'b0;
        key_i  = '0;
        test_mode_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        expect_out("R1 reset", 1'b0, 8'h00);
        n_checks++;
        if (key_o !== 8'h00) begin
            n_fails++;
            $display("FAIL R1: key_o=%02h expected 00", key_o);
        end
        idle("R2 idle", 3);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            for (int r = 0; r < int'(VECS[v].reps); r++) begin
                poll_once($sformatf("R%0d row %0d poll %0d", VECS[v].req, v, r),
                          VECS[v].key, VECS[v].test, VECS[v].ev, VECS[v].ek);
            end
        end

        // R2: strobe lasts one cycle
        poll_once("R2 strobe", 8'h30, 1'b0, 1'b1, 8'h30);
        idle("R2 strobe drops", 1);

        // R10: idle gaps do not advance or reset the pause
        poll_once("R10 start", 8'h55, 1'b0, 1'b1, 8'h55);
        for (int i = 0; i < 20; i++) begin
            idle("R10 gap", 3);
            poll_once("R10 gapped hold", 8'h55, 1'b0, 1'b0, 8'h00);
        end
        idle("R10 gap", 7);
        poll_once("R10 gapped repeat", 8'h55, 1'b0, 1'b1, 8'h55);
        idle("R10 gap", 2);
        for (int i = 0; i < 4; i++) begin
            poll_once("R10 gapped short", 8'h55, 1'b0, 1'b0, 8'h00);
            idle("R10 gap", 1);
        end
        poll_once("R10 short repeat", 8'h55, 1'b0, 1'b1, 8'h55);

        // R1: reset mid-hold forgets the key
        poll_once("R1 pre-reset hold", 8'h55, 1'b0, 1'b0, 8'h00);
        do_reset();
        expect_out("R1 after reset", 1'b0, 8'h00);
        poll_once("R1 same key after reset", 8'h55, 1'b0, 1'b1, 8'h55);
        poll_once("R1 pause restarted", 8'h55, 1'b0, 1'b0, 8'h00);

        // R8 then R3: zero with normal mode, then a brand new key
        poll_once("R8 zero", 8'h00, 1'b0, 1'b0, 8'h00);
        poll_once("R3 new after zero", 8'h7E, 1'b0, 1'b1, 8'h7E);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule